// File: doc/BRIEF.md
# Auxiliary Memory Size Probe

This block works out how much expansion memory sits behind an auxiliary memory controller by testing how its address space folds onto itself. On a start pulse it waits for the controller to report ready. It then programs a provisional size code and writes a marker word to a handful of chosen addresses. Next it overwrites the base of the expansion region with a different probe word. Finally it reads back selected addresses. When a readback returns the probe word, that address aliases onto the expansion base, and the first such hit fixes the fitted size.

Each transfer goes out on a simple block request port: one 32-byte block per request, filled with the 32-bit word repeated. The memory side ends each transfer with a one-cycle done pulse. For a read, that pulse comes with the first word of the block. At the end the block publishes the expansion size and the total size, writes the final 6-bit configuration code and pulses done. The results stay put until the next probe.

Top module: `mem_size_probe`

## Requirements
- R1: After reset, req_valid, cfg_we and done are low, and exp_size, total_size and cfg_code are all zero.
- R2: After start, no request and no configuration write occur until ctrl_ready is sampled high. One cycle after that sample, cfg_we pulses with cfg_code 0x23, total_size 16 MiB (0x1000000) and exp_size 0, before any request.
- R3: Requests go out in a fixed order. First come six writes (req_write=1): the word 0xBAD1BAD0 to 0x1000000, 0x1200000, 0x2000000, 0x1000200 and 0x1400000, then 0xDEADBEEF to 0x1000000. Then come reads (req_write=0) of 0x1000000, 0x1200000, 0x2000000 and 0x1400000, stopping at the read that settles the size. Only mem_rdata, the first word of each block, is compared.
- R4: req_valid stays high with a stable address and direction until mem_done is sampled. It is then low for exactly one cycle before the next request.
- R5: If the read of 0x1000000 does not return 0xDEADBEEF, exp_size is 0 and the final code is 0x23.
- R6: Otherwise, if the read of 0x1200000 returns 0xDEADBEEF, exp_size is 0x200000 (2 MiB) and the code is 0x03.
- R7: Otherwise, if the read of 0x2000000 returns 0xDEADBEEF, exp_size is 0x400000 (4 MiB) and the code is 0x0B.
- R8: Otherwise, if the read of 0x1400000 returns 0xDEADBEEF, exp_size is 0x1000000 and the code is 0x1B. If it does not, exp_size is 0x2000000 and the code is 0x23.
- R9: total_size equals 0x1000000 plus exp_size.
- R10: done pulses together with the final cfg_we, two cycles after the last mem_done is sampled. A probe makes exactly two configuration writes.
- R11: A start pulse during a probe is ignored. While idle, exp_size, total_size and cfg_code hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (ignored while one runs) |
| ctrl_ready | input | 1 | Memory controller ready flag |
| req_valid | output | 1 | Block request pending |
| req_write | output | 1 | 1 = write block, 0 = read block |
| req_addr | output | ADDR_W (26) | Block address |
| req_wdata | output | 32 | Word repeated across the written block |
| mem_done | input | 1 | One-cycle completion of the pending request |
| mem_rdata | input | 32 | First word of a read block, valid with mem_done |
| cfg_we | output | 1 | Configuration code write strobe |
| cfg_code | output | 6 | Size configuration code |
| exp_size | output | ADDR_W (26) | Detected expansion size in bytes |
| total_size | output | ADDR_W (26) | Internal plus expansion size in bytes |
| done | output | 1 | Probe finished pulse |

## Verification
The configuration write is due one cycle after ready is sampled. Each new request follows one idle cycle after a completion. The verdict, with done and the final code, lands two cycles after the deciding completion. The bench's memory model stamps the cycle count at each completion and at the ready edge, and checks cfg_we and done against those stamps at exactly those offsets. Final values are read one cycle after done, and again several idle cycles later to confirm they hold.

// File: rtl/probe_pkg.sv
package probe_pkg;

  localparam int STEP_W     = 4;
  localparam int NUM_WRITES = 6;
  localparam int NUM_STEPS  = 10;

  localparam logic [31:0] MARKER_WORD = 32'hBAD1_BAD0;
  localparam logic [31:0] PROBE_WORD  = 32'hDEAD_BEEF;

  localparam logic [5:0] CODE_BOOT = 6'h23;
  localparam logic [5:0] CODE_2M   = 6'h03;
  localparam logic [5:0] CODE_4M   = 6'h0B;
  localparam logic [5:0] CODE_16M  = 6'h1B;
  localparam logic [5:0] CODE_32M  = 6'h23;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_RDY,
    ST_INIT,
    ST_REQ,
    ST_STEP,
    ST_FIN
  } probe_state_t;

  // internal size, the base of the expansion region
  function automatic logic [31:0] base_of(input int lg);
    return 32'd1 << lg;
  endfunction

  // address of each sequence step: steps 0..5 write, 6..9 read
  function automatic logic [31:0] probe_addr(input logic [STEP_W-1:0] step, input int lg);
    logic [31:0] b;
    b = base_of(lg);
    case (step)
      4'd0, 4'd5, 4'd6: return b;
      4'd1, 4'd7:       return b + (b >> 3);
      4'd2, 4'd8:       return b << 1;
      4'd3:             return b + 32'h200;
      4'd4, 4'd9:       return b + (b >> 2);
      default:          return b;
    endcase
  endfunction

  function automatic logic step_is_write(input logic [STEP_W-1:0] step);
    return step < STEP_W'(NUM_WRITES);
  endfunction

  function automatic logic [31:0] step_word(input logic [STEP_W-1:0] step);
    return (step == STEP_W'(NUM_WRITES - 1)) ? PROBE_WORD : MARKER_WORD;
  endfunction

  // which readback a step is (0..3)
  function automatic logic [1:0] read_slot(input logic [STEP_W-1:0] step);
    case (step)
      4'd7:    return 2'd1;
      4'd8:    return 2'd2;
      4'd9:    return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  function automatic logic [31:0] total_of(input logic [31:0] exp_bytes, input int lg);
    return base_of(lg) + exp_bytes;
  endfunction

endpackage

// File: rtl/probe_step_gen.sv
module probe_step_gen
  import probe_pkg::*;
#(
  parameter int INT_LOG2 = 24,
  parameter int ADDR_W   = INT_LOG2 + 2
) (
  input  logic [STEP_W-1:0] step,
  output logic [ADDR_W-1:0] addr,
  output logic              is_write,
  output logic [31:0]       wword,
  output logic [1:0]        slot,
  output logic              last_step
);

  always_comb begin
    addr      = ADDR_W'(probe_addr(step, INT_LOG2));
    is_write  = step_is_write(step);
    wword     = is_write ? step_word(step) : 32'h0;
    slot      = read_slot(step);
    last_step = (step == STEP_W'(NUM_STEPS - 1));
  end

endmodule

// File: rtl/probe_verdict.sv
module probe_verdict
  import probe_pkg::*;
#(
  parameter int INT_LOG2 = 24,
  parameter int ADDR_W   = INT_LOG2 + 2
) (
  input  logic [1:0]        slot,
  input  logic              hit,
  output logic              finish,
  output logic [ADDR_W-1:0] exp_bytes,
  output logic [5:0]        code
);

  localparam logic [31:0] BASE = 32'd1 << INT_LOG2;

  always_comb begin
    finish    = 1'b0;
    exp_bytes = '0;
    code      = CODE_BOOT;
    case (slot)
      2'd0: begin
        // no echo at the expansion base: nothing fitted
        finish = !hit;
      end
      2'd1: begin
        finish = hit;
        if (hit) begin
          exp_bytes = ADDR_W'(BASE >> 3);
          code      = CODE_2M;
        end
      end
      2'd2: begin
        finish = hit;
        if (hit) begin
          exp_bytes = ADDR_W'(BASE >> 2);
          code      = CODE_4M;
        end
      end
      default: begin
        finish = 1'b1;
        if (hit) begin
          exp_bytes = ADDR_W'(BASE);
          code      = CODE_16M;
        end else begin
          exp_bytes = ADDR_W'(BASE << 1);
          code      = CODE_32M;
        end
      end
    endcase
  end

endmodule

// File: rtl/probe_result_reg.sv
module probe_result_reg
  import probe_pkg::*;
#(
  parameter int INT_LOG2 = 24,
  parameter int ADDR_W   = INT_LOG2 + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_init,
  input  logic              load_final,
  input  logic [ADDR_W-1:0] exp_in,
  input  logic [5:0]        code_in,
  output logic [ADDR_W-1:0] exp_size,
  output logic [ADDR_W-1:0] total_size,
  output logic [5:0]        cfg_code
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      exp_size   <= '0;
      total_size <= '0;
      cfg_code   <= '0;
    end else if (load_init) begin
      exp_size   <= '0;
      total_size <= ADDR_W'(base_of(INT_LOG2));
      cfg_code   <= CODE_BOOT;
    end else if (load_final) begin
      exp_size   <= exp_in;
      total_size <= ADDR_W'(total_of(32'(exp_in), INT_LOG2));
      cfg_code   <= code_in;
    end
  end

endmodule

// File: rtl/mem_size_probe.sv
module mem_size_probe
  import probe_pkg::*;
#(
  parameter int INT_LOG2 = 24,
  parameter int ADDR_W   = INT_LOG2 + 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              ctrl_ready,
  output logic              req_valid,
  output logic              req_write,
  output logic [ADDR_W-1:0] req_addr,
  output logic [31:0]       req_wdata,
  input  logic              mem_done,
  input  logic [31:0]       mem_rdata,
  output logic              cfg_we,
  output logic [5:0]        cfg_code,
  output logic [ADDR_W-1:0] exp_size,
  output logic [ADDR_W-1:0] total_size,
  output logic              done
);

  probe_state_t      state_q;
  logic [STEP_W-1:0] step_q;
  logic              hit_q;

  logic [ADDR_W-1:0] s_addr;
  logic              s_write;
  logic [31:0]       s_word;
  logic [1:0]        s_slot;
  logic              s_last;

  logic              v_finish;
  logic [ADDR_W-1:0] v_exp;
  logic [5:0]        v_code;

  // named internal events
  logic ev_ready_seen;
  logic ev_xfer_done;
  logic ev_verdict;
  logic ev_finish;
  logic probe_busy;

  probe_step_gen #(.INT_LOG2(INT_LOG2), .ADDR_W(ADDR_W)) u_steps (
    .step      (step_q),
    .addr      (s_addr),
    .is_write  (s_write),
    .wword     (s_word),
    .slot      (s_slot),
    .last_step (s_last)
  );

  probe_verdict #(.INT_LOG2(INT_LOG2), .ADDR_W(ADDR_W)) u_verdict (
    .slot      (s_slot),
    .hit       (hit_q),
    .finish    (v_finish),
    .exp_bytes (v_exp),
    .code      (v_code)
  );

  assign ev_ready_seen = (state_q == ST_WAIT_RDY) && ctrl_ready;
  assign ev_xfer_done  = (state_q == ST_REQ) && mem_done;
  assign ev_verdict    = (state_q == ST_STEP) && !s_write;
  assign ev_finish     = ev_verdict && (v_finish || s_last);
  assign probe_busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      step_q  <= '0;
      hit_q   <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE:     if (start) state_q <= ST_WAIT_RDY;
        ST_WAIT_RDY: if (ctrl_ready) state_q <= ST_INIT;
        ST_INIT: begin
          step_q  <= '0;
          state_q <= ST_REQ;
        end
        ST_REQ: begin
          if (mem_done) begin
            hit_q   <= (mem_rdata == PROBE_WORD);
            state_q <= ST_STEP;
          end
        end
        ST_STEP: begin
          if (ev_finish) begin
            state_q <= ST_FIN;
          end else begin
            step_q  <= step_q + STEP_W'(1);
            state_q <= ST_REQ;
          end
        end
        ST_FIN:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  probe_result_reg #(.INT_LOG2(INT_LOG2), .ADDR_W(ADDR_W)) u_result (
    .clk        (clk),
    .rst_n      (rst_n),
    .load_init  (ev_ready_seen),
    .load_final (ev_finish),
    .exp_in     (v_exp),
    .code_in    (v_code),
    .exp_size   (exp_size),
    .total_size (total_size),
    .cfg_code   (cfg_code)
  );

  always_comb begin
    req_valid = (state_q == ST_REQ);
    req_write = s_write;
    req_addr  = s_addr;
    req_wdata = s_word;
    cfg_we    = (state_q == ST_INIT) || (state_q == ST_FIN);
    done      = (state_q == ST_FIN);
  end

endmodule

// File: rtl/probe_checker.sv
module probe_checker #(
  parameter int INT_LOG2 = 24,
  parameter int ADDR_W   = INT_LOG2 + 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              mem_done,
  input logic              cfg_we,
  input logic [5:0]        cfg_code,
  input logic [ADDR_W-1:0] exp_size,
  input logic [ADDR_W-1:0] total_size,
  input logic              done,
  input logic              probe_busy
);

  localparam logic [ADDR_W-1:0] BASE = ADDR_W'(32'd1 << INT_LOG2);

  assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !mem_done) |=> (req_valid && $stable(req_addr) && $stable(req_write)));

  assert_req_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && mem_done) |=> !req_valid);

  assert_cfg_no_req_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |-> !req_valid);

  assert_done_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> cfg_we);

  assert_total_sum_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (total_size == BASE + exp_size));

  assert_code_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cfg_code == 6'h23 || cfg_code == 6'h03 || cfg_code == 6'h0B || cfg_code == 6'h1B));

  assert_idle_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!probe_busy && !start) |=> ($stable(exp_size) && $stable(total_size) && $stable(cfg_code)));

  assert_busy_start_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && start) |=> probe_busy);

endmodule

bind mem_size_probe probe_checker #(.INT_LOG2(INT_LOG2), .ADDR_W(ADDR_W)) u_probe_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .start      (start),
  .req_valid  (req_valid),
  .req_write  (req_write),
  .req_addr   (req_addr),
  .mem_done   (mem_done),
  .cfg_we     (cfg_we),
  .cfg_code   (cfg_code),
  .exp_size   (exp_size),
  .total_size (total_size),
  .done       (done),
  .probe_busy (probe_busy)
);

// File: tb/tb_mem_size_probe.sv
`timescale 1ns/1ps
module tb_mem_size_probe;

  localparam int          AW  = 26;
  localparam logic [31:0] INT = 32'h0100_0000;

  logic clk = 1'b0;
  logic rst_n, start, ctrl_ready, mem_done;
  logic [31:0] mem_rdata;
  logic req_valid, req_write, cfg_we, done;
  logic [AW-1:0] req_addr, exp_size, total_size;
  logic [31:0] req_wdata;
  logic [5:0] cfg_code;

  mem_size_probe dut (
    .clk(clk), .rst_n(rst_n), .start(start), .ctrl_ready(ctrl_ready),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .mem_done(mem_done), .mem_rdata(mem_rdata),
    .cfg_we(cfg_we), .cfg_code(cfg_code), .exp_size(exp_size),
    .total_size(total_size), .done(done)
  );

  always #2.5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int cfg_sel = 0;
  int req_idx, cfg_cnt, done_cnt, lat;
  bit m_busy = 0;
  longint ready_cyc, last_op_cyc;
  logic [31:0] mem [int unsigned];

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, expv);
    end
  endtask

  // R3 request order
  function automatic logic [31:0] exp_addr(input int i);
    case (i)
      0, 5, 6: return 32'h0100_0000;
      1, 7:    return 32'h0120_0000;
      2, 8:    return 32'h0200_0000;
      3:       return 32'h0100_0200;
      4, 9:    return 32'h0140_0000;
      default: return 32'hFFFF_FFFF;
    endcase
  endfunction

  function automatic int n_reads(input int c);
    return (c == 0) ? 1 : (c == 1) ? 2 : (c == 2) ? 3 : 4;
  endfunction

  function automatic logic [31:0] exp_of(input int c);
    case (c)
      1: return 32'h0020_0000;
      2: return 32'h0040_0000;
      3: return 32'h0100_0000;
      4: return 32'h0200_0000;
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [5:0] code_of(input int c);
    case (c)
      1: return 6'h03;
      2: return 6'h0B;
      3: return 6'h1B;
      default: return 6'h23;
    endcase
  endfunction

  function automatic string tag_of(input int c);
    case (c)
      0: return "R5";
      1: return "R6";
      2: return "R7";
      default: return "R8";
    endcase
  endfunction

  // memory model: fold expansion addresses by dropping address bits
  function automatic logic [31:0] canon(input logic [31:0] a, input int c);
    case (c)
      1: return a & ~(32'h0100_0000 | 32'h0020_0000);
      2: return a & ~(32'h0100_0000 | 32'h0200_0000);
      3: return a & ~(32'h0100_0000 | 32'h0040_0000);
      default: return a & ~32'h0100_0000;
    endcase
  endfunction

  task automatic do_op();
    logic [31:0] a, k, junk;
    a = 32'(req_addr);
    check(a == exp_addr(req_idx), "R3", "request address", a, exp_addr(req_idx));
    check(req_write == (req_idx < 6), "R3", "request direction", 32'(req_write), 32'(req_idx < 6));
    if (req_idx < 6)
      check(req_wdata == ((req_idx == 5) ? 32'hDEAD_BEEF : 32'hBAD1_BAD0), "R3", "write word",
            req_wdata, (req_idx == 5) ? 32'hDEAD_BEEF : 32'hBAD1_BAD0);
    k = canon(a, cfg_sel);
    if (req_write) begin
      if (!(cfg_sel == 0 && a >= INT)) mem[k] = req_wdata;
    end else if (cfg_sel == 0 && a >= INT) begin
      junk = $urandom;
      if (junk == 32'hDEAD_BEEF) junk = 32'h0;
      mem_rdata = junk;
    end else begin
      mem_rdata = mem.exists(k) ? mem[k] : 32'h0;
    end
    last_op_cyc = cyc;
    req_idx++;
  endtask

  always @(negedge clk) begin
    if (mem_done === 1'b1) begin
      mem_done = 1'b0;
    end else if (rst_n === 1'b1 && req_valid === 1'b1) begin
      if (!m_busy) begin
        m_busy = 1'b1;
        lat = $urandom_range(0, 5);
      end
      if (lat == 0) begin
        do_op();
        mem_done = 1'b1;
        m_busy = 1'b0;
      end else begin
        lat--;
      end
    end
    if (rst_n === 1'b1 && cfg_we === 1'b1) begin
      cfg_cnt++;
      if (cfg_cnt == 1) begin
        check(cfg_code == 6'h23, "R2", "boot code", 32'(cfg_code), 32'h23);
        check(total_size == AW'(INT), "R2", "boot total", 32'(total_size), INT);
        check(exp_size == '0, "R2", "boot expansion", 32'(exp_size), 32'h0);
        check(req_idx == 0, "R2", "requests before boot write", req_idx, 0);
        check(cyc == ready_cyc + 1, "R2", "boot write cycle", 32'(cyc - ready_cyc), 32'd1);
      end
    end
    if (rst_n === 1'b1 && done === 1'b1) begin
      done_cnt++;
      check(cyc == last_op_cyc + 2, "R10", "done latency", 32'(cyc - last_op_cyc), 32'd2);
      check(cfg_we === 1'b1, "R10", "final cfg write with done", 32'(cfg_we), 32'd1);
    end
  end

  task automatic run_probe(input int c, input bit poke);
    int n;
    logic [AW-1:0] e_hold, t_hold;
    logic [5:0] c_hold;
    cfg_sel = c;
    mem.delete();
    req_idx = 0; cfg_cnt = 0; done_cnt = 0;
    @(negedge clk) start = 1'b1;
    @(negedge clk) start = 1'b0;
    repeat ($urandom_range(1, 6)) @(negedge clk);
    ctrl_ready = 1'b1;
    ready_cyc = cyc;
    if (poke) begin
      repeat (4) @(negedge clk);
      start = 1'b1;
      @(negedge clk) start = 1'b0;
    end
    n = 0;
    while (done !== 1'b1 && n < 3000) begin
      @(negedge clk);
      n++;
    end
    check(n < 3000, "R10", "probe completion", n, 3000);
    @(negedge clk);
    ctrl_ready = 1'b0;
    check(exp_size == AW'(exp_of(c)), tag_of(c), "expansion size", 32'(exp_size), exp_of(c));
    check(cfg_code == code_of(c), tag_of(c), "final code", 32'(cfg_code), 32'(code_of(c)));
    check(total_size == AW'(INT + exp_of(c)), "R9", "total size", 32'(total_size), INT + exp_of(c));
    check(req_idx == 6 + n_reads(c), "R3", "request count", req_idx, 6 + n_reads(c));
    check(cfg_cnt == 2, "R10", "cfg write count", cfg_cnt, 2);
    check(done_cnt == 1, poke ? "R11" : "R10", "done count", done_cnt, 1);
    e_hold = exp_size; t_hold = total_size; c_hold = cfg_code;
    repeat (5) @(negedge clk);
    check(exp_size == e_hold && total_size == t_hold && cfg_code == c_hold, "R11",
          "idle hold", 32'(total_size), 32'(t_hold));
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL R10 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd4711));
    rst_n = 1'b0; start = 1'b0; ctrl_ready = 1'b0; mem_rdata = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(!req_valid && !cfg_we && !done, "R1", "reset strobes",
          {29'h0, req_valid, cfg_we, done}, 32'h0);
    check(exp_size == '0 && total_size == '0 && cfg_code == '0, "R1", "reset results",
          32'(total_size), 32'h0);
    repeat (3) @(negedge clk);
    check(!req_valid && !cfg_we, "R2", "idle without start", 32'(req_valid), 32'h0);
    for (int c = 0; c < 5; c++) run_probe(c, 1'b0);
    run_probe(4, 1'b1);
    run_probe(1, 1'b1);
    for (int i = 0; i < 40; i++) run_probe($urandom_range(0, 4), ($urandom_range(0, 3) == 0));
    finish_run();
  end

endmodule